// File: doc/BRIEF.md
# NAND Flash Bus Bridge

This block lets a processor drive raw NAND flash devices through plain memory-mapped byte accesses. It has two address spaces. The top address bit selects a small register space. When that bit is clear, the access goes to the shared flash bus. In the flash space, two high offset bits choose what kind of bus cycle the byte produces: a command latch cycle, an address latch cycle or an ordinary data cycle. Software can therefore send a full flash command sequence with ordinary stores and loads. The bridge does not sequence commands itself.

Each flash access is stretched into a setup phase, a strobe phase and a hold phase. Each phase lasts a programmable number of clock cycles. The bus is stalled through `wait_o` until the hold phase ends. Chip enables are not tied to individual accesses. A select register asserts the enable of one bank and keeps it asserted across as many accesses as software needs. A small table maps consecutive logical chip numbers onto physical bank numbers, which need not be consecutive.

A ready/busy pin is resynchronised and its polarity corrected, then exposed as a status bit. A write-protect output level is formed from a protect bit and a polarity bit.

Top module: `nand_bridge`

## Requirements
- R1: In the flash space (address bit 24 clear), offset bit 23 set makes an address cycle with `ale_o` high. Bit 22 set with bit 23 clear makes a command cycle with `cle_o` high. Both bits clear make a data cycle with `cle_o` and `ale_o` low. With both bits set, the access is an address cycle.
- R2: A flash write drives `wdata_i` on `dq_o` with `dq_oe_o` high for S setup, P strobe and H hold cycles. `we_no` is low only during the P strobe cycles. `cle_o`/`ale_o` are held high for all S+P+H cycles. `wait_o` is high for 1+S+P+H cycles, and the access completes in the next cycle.
- R3: A flash read at a data offset pulls `re_no` low for P cycles with `dq_oe_o` low. It returns on `rdata_o`, in the completion cycle, the value of `dq_i` sampled in the last strobe cycle. The stall lasts 1+S+P+H cycles.
- R4: A read at a command or address offset completes in its first cycle with no stall and no strobe, and returns 0.
- R5: Registers 2, 3 and 4 hold S, P and H (4 bits each, range 1..15). Writing 0 stores 1. Their reset values are 2, 3 and 1.
- R6: Writing register 0 with bit 7 set and a chip number in bits 1:0 asserts (drives low) the `ce_no` bit of the bank that chip maps to, and remembers that bank. Writing it with bit 7 clear deasserts the remembered bank only. A second such write changes nothing. Reading register 0 returns the asserted enables as a bank bitmask. Flash accesses never change `ce_no`.
- R7: Registers 8+i hold the physical bank number of logical chip i. After reset, entry i holds i.
- R8: `rb_i` passes through two flops. Status register 5, bit 0, reads ready = synchronised pin XOR register 1 bit 2. The result changes two clock edges after the pin changes. Writes to register 5 are ignored.
- R9: `wp_o` equals register 1 bit 0 XOR register 1 bit 1.
- R10: After reset: all `ce_no` high, `we_no` and `re_no` high, `cle_o`, `ale_o`, `dq_oe_o`, `wait_o` and `wp_o` low, and register 1 is 0.
- R11: `cle_o` and `ale_o` are never high together. `we_no` and `re_no` are never low together. A strobe is only low while `wait_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, held until `wait_o` is low |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address; top bit selects register space |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in completion cycle |
| wait_o | output | 1 | Stall; access completes when low with `req_i` high |
| rb_i | input | 1 | Flash ready/busy pin |
| dq_i | input | 8 | Flash data bus in |
| dq_o | output | 8 | Flash data bus out |
| dq_oe_o | output | 1 | Flash data bus output enable |
| cle_o | output | 1 | Command latch enable |
| ale_o | output | 1 | Address latch enable |
| we_no | output | 1 | Write strobe, active low |
| re_no | output | 1 | Read strobe, active low |
| ce_no | output | NUM_BANKS | Per-bank chip enable, active low |
| wp_o | output | 1 | Write-protect pin level |

## Verification
Writes are issued at data, command and address offsets, and at an offset with both select bits set. This separates the four decode outcomes and the priority of the address bit. The writes use the default timing, a wider timing and a timing written as zero. Stall length and strobe width then show whether setup, strobe and hold are counted separately and whether zero is clamped. Reads at a data offset and at a command offset separate the strobed path from the immediate path. A remapped chip number is selected, then a second one, then deselected twice. This shows that only the remembered bank is released. The ready/busy pin is toggled under both polarities and read back one and two edges later, which exposes the synchroniser depth.

// File: rtl/nand_br_pkg.sv
package nand_br_pkg;
  typedef enum logic [1:0] {
    CYC_DATA = 2'd0,
    CYC_CMD  = 2'd1,
    CYC_ADDR = 2'd2
  } cyc_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_PULSE,
    ST_HOLD,
    ST_DONE
  } st_e;

  localparam int unsigned CLE_BIT = 22;
  localparam int unsigned ALE_BIT = 23;

  localparam logic [3:0] RG_SEL  = 4'd0;
  localparam logic [3:0] RG_CFG  = 4'd1;
  localparam logic [3:0] RG_TSU  = 4'd2;
  localparam logic [3:0] RG_TPW  = 4'd3;
  localparam logic [3:0] RG_THD  = 4'd4;
  localparam logic [3:0] RG_STAT = 4'd5;
  localparam logic [3:0] RG_MAP  = 4'd8;

  // address bit wins over command bit
  function automatic cyc_e decode_cyc(input logic ale_bit, input logic cle_bit);
    if (ale_bit)      return CYC_ADDR;
    else if (cle_bit) return CYC_CMD;
    else              return CYC_DATA;
  endfunction
endpackage

// File: rtl/nand_br_sync.sv
module nand_br_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) ff_q[g] <= 1'b0;
          else         ff_q[g] <= d_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) ff_q[g] <= 1'b0;
          else         ff_q[g] <= ff_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/nand_br_regs.sv
module nand_br_regs
  import nand_br_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned NUM_CHIPS = 4,
  parameter int unsigned TW        = 4,
  parameter int unsigned DEF_SETUP = 2,
  parameter int unsigned DEF_PULSE = 3,
  parameter int unsigned DEF_HOLD  = 1,
  localparam int unsigned BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int unsigned CHIP_W   = (NUM_CHIPS > 1) ? $clog2(NUM_CHIPS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [3:0]           idx_i,
  input  logic [7:0]           wdata_i,
  input  logic                 ready_i,
  output logic [7:0]           rdata_o,
  output logic [NUM_BANKS-1:0] ce_no,
  output logic                 wp_o,
  output logic                 rb_low_o,
  output logic [TW-1:0]        t_setup_o,
  output logic [TW-1:0]        t_pulse_o,
  output logic [TW-1:0]        t_hold_o
);
  logic [NUM_BANKS-1:0] ce_q;
  logic [BANK_W-1:0]    sel_bank_q;
  logic                 sel_vld_q;
  logic [2:0]           cfg_q;
  logic [TW-1:0]        tsu_q, tpw_q, thd_q;
  logic [BANK_W-1:0]    map_q [NUM_CHIPS];

  logic [CHIP_W-1:0]    chip;
  logic [BANK_W-1:0]    chip_bank;
  logic                 chip_ok;
  logic [TW-1:0]        t_wr;

  assign chip      = wdata_i[CHIP_W-1:0];
  assign chip_ok   = (int'(chip) < NUM_CHIPS);
  assign chip_bank = chip_ok ? map_q[chip] : '0;
  assign t_wr      = (wdata_i[TW-1:0] == '0) ? TW'(1) : wdata_i[TW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q       <= '0;
      sel_bank_q <= '0;
      sel_vld_q  <= 1'b0;
      cfg_q      <= '0;
      tsu_q      <= TW'(DEF_SETUP);
      tpw_q      <= TW'(DEF_PULSE);
      thd_q      <= TW'(DEF_HOLD);
      for (int i = 0; i < NUM_CHIPS; i++) map_q[i] <= BANK_W'(i);
    end else if (wr_i) begin
      case (idx_i)
        RG_SEL: begin
          if (wdata_i[7]) begin
            if (chip_ok) begin
              ce_q[chip_bank] <= 1'b1;
              sel_bank_q      <= chip_bank;
              sel_vld_q       <= 1'b1;
            end
          end else if (sel_vld_q) begin
            ce_q[sel_bank_q] <= 1'b0;
            sel_vld_q        <= 1'b0;
          end
        end
        RG_CFG: cfg_q <= wdata_i[2:0];
        RG_TSU: tsu_q <= t_wr;
        RG_TPW: tpw_q <= t_wr;
        RG_THD: thd_q <= t_wr;
        default: begin
          for (int i = 0; i < NUM_CHIPS; i++)
            if (idx_i == RG_MAP + 4'(i)) map_q[i] <= wdata_i[BANK_W-1:0];
        end
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (idx_i)
      RG_SEL:  rdata_o[NUM_BANKS-1:0] = ce_q;
      RG_CFG:  rdata_o[2:0] = cfg_q;
      RG_TSU:  rdata_o[TW-1:0] = tsu_q;
      RG_TPW:  rdata_o[TW-1:0] = tpw_q;
      RG_THD:  rdata_o[TW-1:0] = thd_q;
      RG_STAT: rdata_o[0] = ready_i;
      default: begin
        for (int i = 0; i < NUM_CHIPS; i++)
          if (idx_i == RG_MAP + 4'(i)) rdata_o[BANK_W-1:0] = map_q[i];
      end
    endcase
  end

  assign ce_no     = ~ce_q;
  assign wp_o      = cfg_q[0] ^ cfg_q[1];
  assign rb_low_o  = cfg_q[2];
  assign t_setup_o = tsu_q;
  assign t_pulse_o = tpw_q;
  assign t_hold_o  = thd_q;
endmodule

// File: rtl/nand_br_strobe.sv
module nand_br_strobe
  import nand_br_pkg::*;
#(
  parameter int unsigned TW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          we_i,
  input  cyc_e          cyc_i,
  input  logic [7:0]    wdata_i,
  input  logic [7:0]    dq_i,
  input  logic [TW-1:0] t_setup_i,
  input  logic [TW-1:0] t_pulse_i,
  input  logic [TW-1:0] t_hold_i,
  output logic          idle_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [7:0]    rdata_o,
  output logic [7:0]    dq_o,
  output logic          dq_oe_o,
  output logic          cle_o,
  output logic          ale_o,
  output logic          we_no,
  output logic          re_no
);
  st_e           st_q;
  logic [TW-1:0] cnt_q;
  logic          wr_q;
  cyc_e          cyc_q;
  logic [7:0]    dout_q, din_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      wr_q   <= 1'b0;
      cyc_q  <= CYC_DATA;
      dout_q <= '0;
      din_q  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          st_q   <= ST_SETUP;
          cnt_q  <= t_setup_i - TW'(1);
          wr_q   <= we_i;
          cyc_q  <= cyc_i;
          dout_q <= wdata_i;
        end
        ST_SETUP: if (cnt_q == '0) begin
          st_q  <= ST_PULSE;
          cnt_q <= t_pulse_i - TW'(1);
        end else cnt_q <= cnt_q - TW'(1);
        ST_PULSE: if (cnt_q == '0) begin
          st_q  <= ST_HOLD;
          cnt_q <= t_hold_i - TW'(1);
          if (!wr_q) din_q <= dq_i;
        end else cnt_q <= cnt_q - TW'(1);
        ST_HOLD: if (cnt_q == '0) st_q <= ST_DONE;
                 else cnt_q <= cnt_q - TW'(1);
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o  = (st_q == ST_IDLE);
  assign busy_o  = (st_q == ST_SETUP) || (st_q == ST_PULSE) || (st_q == ST_HOLD);
  assign done_o  = (st_q == ST_DONE);
  assign rdata_o = din_q;
  assign dq_o    = dout_q;
  assign dq_oe_o = busy_o & wr_q;
  assign cle_o   = busy_o & (cyc_q == CYC_CMD);
  assign ale_o   = busy_o & (cyc_q == CYC_ADDR);
  assign we_no   = ~((st_q == ST_PULSE) & wr_q);
  assign re_no   = ~((st_q == ST_PULSE) & ~wr_q);
endmodule

// File: rtl/nand_bridge.sv
module nand_bridge
  import nand_br_pkg::*;
#(
  parameter int unsigned ADDR_W    = 25,
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned NUM_CHIPS = 4,
  parameter int unsigned TW        = 4,
  parameter int unsigned SYNC_N    = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [7:0]           wdata_i,
  output logic [7:0]           rdata_o,
  output logic                 wait_o,
  input  logic                 rb_i,
  input  logic [7:0]           dq_i,
  output logic [7:0]           dq_o,
  output logic                 dq_oe_o,
  output logic                 cle_o,
  output logic                 ale_o,
  output logic                 we_no,
  output logic                 re_no,
  output logic [NUM_BANKS-1:0] ce_no,
  output logic                 wp_o
);
  logic          reg_sel, idle, busy, done, start, reg_wr, flash_ok;
  logic          rb_sync, rb_low, ready;
  cyc_e          cyc;
  logic [7:0]    reg_rdata, fl_rdata;
  logic [TW-1:0] t_setup, t_pulse, t_hold;

  assign reg_sel  = addr_i[ADDR_W-1];
  assign cyc      = decode_cyc(addr_i[ALE_BIT], addr_i[CLE_BIT]);
  assign flash_ok = we_i | (cyc == CYC_DATA);
  assign start    = req_i & idle & ~reg_sel & flash_ok;
  assign reg_wr   = req_i & idle & reg_sel & we_i;
  assign wait_o   = start | busy;
  assign ready    = rb_sync ^ rb_low;

  always_comb begin
    if (done)                         rdata_o = fl_rdata;
    else if (req_i & idle & reg_sel)  rdata_o = reg_rdata;
    else                              rdata_o = '0;
  end

  nand_br_sync #(.STAGES(SYNC_N)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rb_i),
    .q_o   (rb_sync)
  );

  nand_br_regs #(
    .NUM_BANKS(NUM_BANKS),
    .NUM_CHIPS(NUM_CHIPS),
    .TW       (TW)
  ) i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (reg_wr),
    .idx_i    (addr_i[3:0]),
    .wdata_i  (wdata_i),
    .ready_i  (ready),
    .rdata_o  (reg_rdata),
    .ce_no    (ce_no),
    .wp_o     (wp_o),
    .rb_low_o (rb_low),
    .t_setup_o(t_setup),
    .t_pulse_o(t_pulse),
    .t_hold_o (t_hold)
  );

  nand_br_strobe #(.TW(TW)) i_strobe (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .we_i     (we_i),
    .cyc_i    (cyc),
    .wdata_i  (wdata_i),
    .dq_i     (dq_i),
    .t_setup_i(t_setup),
    .t_pulse_i(t_pulse),
    .t_hold_i (t_hold),
    .idle_o   (idle),
    .busy_o   (busy),
    .done_o   (done),
    .rdata_o  (fl_rdata),
    .dq_o     (dq_o),
    .dq_oe_o  (dq_oe_o),
    .cle_o    (cle_o),
    .ale_o    (ale_o),
    .we_no    (we_no),
    .re_no    (re_no)
  );
endmodule

// File: rtl/nand_bridge_chk.sv
module nand_bridge_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wait_o,
  input logic cle_o,
  input logic ale_o,
  input logic we_no,
  input logic re_no,
  input logic dq_oe_o
);
  logic [4:0] we_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     we_run_q <= '0;
    else if (!we_no) we_run_q <= (we_run_q == 5'd31) ? we_run_q : we_run_q + 5'd1;
    else             we_run_q <= '0;
  end

  p_latch_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cle_o && ale_o));
  p_strobe_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!we_no && !re_no));
  p_strobe_stall_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_no || !re_no) |-> wait_o);
  p_cmd_is_write_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cle_o || ale_o) |-> dq_oe_o);
  p_read_no_drive_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_no |-> !dq_oe_o);
  p_pulse_max_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_run_q <= 5'd15);
endmodule

bind nand_bridge nand_bridge_chk i_nand_bridge_chk (.*);

// File: tb/test_nand_bridge.sv
`timescale 1ns/1ps
module test_nand_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [24:0] addr = '0;
  logic [7:0]  wdata = '0, dq_in = '0;
  logic        rb = 1'b0;
  logic [7:0]  rdata, dq_out;
  logic        wait_s, dq_oe, cle, ale, we_n, re_n, wp;
  logic [3:0]  ce_n;

  int errs = 0, total = 0;

  always #10 clk = ~clk;

  nand_bridge i_nand_bridge (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .wait_o(wait_s), .rb_i(rb),
    .dq_i(dq_in), .dq_o(dq_out), .dq_oe_o(dq_oe), .cle_o(cle), .ale_o(ale),
    .we_no(we_n), .re_no(re_n), .ce_no(ce_n), .wp_o(wp)
  );

  localparam logic [24:0] REG  = 25'h1000000;
  localparam logic [24:0] OCMD = 25'h0400000;
  localparam logic [24:0] OADR = 25'h0800000;

  // per-access observations
  logic [7:0] o_rd, o_dq;
  int o_wait, o_we, o_re, o_cle, o_ale;

  task automatic chk(input string r, input int act, input int exp);
    total++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [24:0] a, input logic [7:0] d);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    o_wait = 0; o_we = 0; o_re = 0; o_cle = 0; o_ale = 0; o_rd = '0; o_dq = '0;
    forever begin
      #1;
      if (!we_n) begin o_we++; o_dq = dq_out; end
      if (!re_n) o_re++;
      if (cle) o_cle++;
      if (ale) o_ale++;
      if (!wait_s) begin o_rd = rdata; break; end
      o_wait++;
      @(negedge clk);
    end
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic reg_wr(input logic [3:0] idx, input logic [7:0] v);
    access(1'b1, REG | 25'(idx), v);
  endtask

  task automatic reg_rd(input logic [3:0] idx);
    access(1'b0, REG | 25'(idx), 8'h00);
  endtask

  task automatic t_reset;
    chk("R10 ce_no", ce_n, 4'hF);
    chk("R10 we_no", we_n, 1);
    chk("R10 re_no", re_n, 1);
    chk("R10 cle/ale", {cle, ale}, 0);
    chk("R10 wait", wait_s, 0);
    chk("R10 wp", wp, 0);
    chk("R10 dq_oe", dq_oe, 0);
    reg_rd(4'd1); chk("R10 cfg", o_rd, 0);
    reg_rd(4'd2); chk("R5 setup reset", o_rd, 2);
    reg_rd(4'd3); chk("R5 pulse reset", o_rd, 3);
    reg_rd(4'd4); chk("R5 hold reset", o_rd, 1);
    reg_rd(4'd10); chk("R7 map reset", o_rd, 2);
  endtask

  task automatic t_decode;
    access(1'b1, 25'h0, 8'hA5);
    chk("R2 data wait", o_wait, 7);
    chk("R2 data we width", o_we, 3);
    chk("R2 data dq", o_dq, 8'hA5);
    chk("R1 data cle/ale", o_cle + o_ale, 0);
    access(1'b1, OCMD, 8'h70);
    chk("R1 cmd cle", o_cle, 6);
    chk("R1 cmd ale", o_ale, 0);
    chk("R1 cmd dq", o_dq, 8'h70);
    access(1'b1, OADR, 8'h12);
    chk("R1 addr ale", o_ale, 6);
    chk("R1 addr cle", o_cle, 0);
    access(1'b1, OCMD | OADR, 8'h34);
    chk("R1 both ale", o_ale, 6);
    chk("R1 both cle", o_cle, 0);
  endtask

  task automatic t_read;
    dq_in = 8'h3C;
    access(1'b0, 25'h0, 8'h00);
    chk("R3 rdata", o_rd, 8'h3C);
    chk("R3 re width", o_re, 3);
    chk("R3 no we", o_we, 0);
    chk("R3 wait", o_wait, 7);
    access(1'b0, OCMD, 8'h00);
    chk("R4 cmd read wait", o_wait, 0);
    chk("R4 cmd read strobe", o_re + o_we, 0);
    chk("R4 cmd read data", o_rd, 0);
    access(1'b0, OADR, 8'h00);
    chk("R4 addr read wait", o_wait, 0);
  endtask

  task automatic t_timing;
    reg_wr(4'd2, 8'd4); reg_wr(4'd3, 8'd5); reg_wr(4'd4, 8'd2);
    access(1'b1, 25'h0, 8'h5A);
    chk("R5 we width 5", o_we, 5);
    chk("R5 wait 1+4+5+2", o_wait, 12);
    reg_wr(4'd3, 8'd0);
    reg_rd(4'd3); chk("R5 zero clamps", o_rd, 1);
    access(1'b1, OCMD, 8'hFF);
    chk("R5 we width 1", o_we, 1);
    chk("R5 wait 1+4+1+2", o_wait, 8);
    reg_wr(4'd3, 8'd15);
    reg_rd(4'd3); chk("R5 max", o_rd, 15);
    reg_wr(4'd2, 8'd2); reg_wr(4'd3, 8'd3); reg_wr(4'd4, 8'd1);
  endtask

  task automatic t_select;
    reg_wr(4'd9, 8'd3);
    reg_rd(4'd9); chk("R7 map write", o_rd, 3);
    reg_wr(4'd0, 8'h81);
    chk("R6 select chip1->bank3", ce_n, 4'b0111);
    reg_rd(4'd0); chk("R6 readback", o_rd, 8'h08);
    reg_wr(4'd0, 8'h80);
    chk("R6 select chip0", ce_n, 4'b0110);
    access(1'b1, 25'h0, 8'h11);
    chk("R6 ce held across access", ce_n, 4'b0110);
    reg_wr(4'd0, 8'h00);
    chk("R6 deselect last only", ce_n, 4'b0111);
    reg_wr(4'd0, 8'h00);
    chk("R6 second deselect", ce_n, 4'b0111);
  endtask

  task automatic t_ready;
    @(negedge clk); rb = 1'b1;
    reg_rd(4'd5); chk("R8 one edge old", o_rd, 0);
    reg_rd(4'd5); chk("R8 active-high ready", o_rd, 1);
    reg_wr(4'd1, 8'h04);
    reg_rd(4'd5); chk("R8 active-low busy", o_rd, 0);
    @(negedge clk); rb = 1'b0;
    reg_rd(4'd5); chk("R8 one edge old lo", o_rd, 0);
    reg_rd(4'd5); chk("R8 active-low ready", o_rd, 1);
    reg_wr(4'd5, 8'h00);
    reg_rd(4'd5); chk("R8 status write ignored", o_rd, 1);
    reg_rd(4'd1); chk("R8 cfg untouched", o_rd, 4);
  endtask

  task automatic t_wp;
    reg_wr(4'd1, 8'h01); chk("R9 protect", wp, 1);
    reg_wr(4'd1, 8'h03); chk("R9 protect inverted", wp, 0);
    reg_wr(4'd1, 8'h02); chk("R9 off inverted", wp, 1);
    reg_wr(4'd1, 8'h00); chk("R9 off", wp, 0);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_decode();
    t_read();
    t_timing();
    t_select();
    t_ready();
    t_wp();
    finish_run();
  end
endmodule